// File: doc/BRIEF.md
# Seconds Countdown Alarm with Wakeup

This block counts down a programmed number of seconds and flags the moment the count runs out. Software writes an interval into the load register. On the next one-second tick that interval is copied into the live counter. While counting is enabled, every further tick takes one off the counter. When the counter reaches zero, a sticky pending flag is set and the counter stays at zero until software loads it again.

The pending flag drives two outputs, each behind its own gate. One is an interrupt, gated by an interrupt-enable bit. The other is a wakeup line, gated by a separate wakeup-configuration bit, so a sleeping system can be woken without an interrupt being taken. Software clears the flag by writing a 1 to it.

A second, weekly alarm is kept only as state. It has an enable, an interrupt enable and a pending bit that software clears. Its match event arrives from outside on an input pin.

Top module: `countdown_alarm`

## Requirements
- R1: After reset every register reads 0 and the outputs `alarmIrq`, `wakeOut` and `weekIrq` are low.
- R2: A write to offset 0x20 stores the 32-bit interval, which reads back at 0x20. The live count at 0x24 takes that value at the first `tick` after the write, whether or not counting is enabled.
- R3: While bit 0 of offset 0x28 is 1, each `tick` lowers the live count by one. With the bit at 0, or with no tick, the count holds.
- R4: The tick that moves the live count from 1 to 0 sets the pending flag (bit 0 of offset 0x30). Later ticks leave the count at 0 and do not set the flag again.
- R5: Writing 1 to bit 0 of offset 0x30 clears the pending flag. Writing 0 to that bit has no effect.
- R6: If a clearing write and a new expiry happen in the same cycle, the pending flag stays set.
- R7: `alarmIrq` is high exactly when the pending flag is set and bit 0 of offset 0x2C is 1.
- R8: `wakeOut` is high exactly when the pending flag is set and bit 0 of offset 0x50 is 1, regardless of the interrupt enable.
- R9: Loading 0 and letting it be copied stops the countdown without any expiry. Loading a new nonzero interval afterwards restarts the countdown from that value.
- R10: The weekly pending flag (bit 0 of offset 0x4C) is set by `weekHit` only while bit 0 of offset 0x44 is 1, and is cleared by writing 1 to it. `weekIrq` is that flag ANDed with bit 0 of offset 0x48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle strobe, once per second |
| weekHit | input | 1 | Weekly alarm match event |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write byte offset |
| wrData | input | 32 | Register write data |
| rdAddr | input | 8 | Register read byte offset |
| rdData | output | 32 | Read data, combinational from rdAddr |
| alarmIrq | output | 1 | Countdown alarm interrupt |
| wakeOut | output | 1 | Countdown alarm wakeup request |
| weekIrq | output | 1 | Weekly alarm interrupt |

## Verification
A live count that lost a tick, or took one twice, shows at offset 0x24 after the very next tick. It also moves the rising edge of `alarmIrq` and `wakeOut` by one second. A reload latch that stayed set, or was never set, shows up at the first tick after a load write, as the wrong live value. A pending flag that fails to stick, or to clear, shows on the outputs in the cycle after the expiry or the clearing write. The case where expiry and clear arrive together is visible only in that single cycle.

// File: rtl/countdown_alarm_pkg.sv
package countdown_alarm_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_LOAD     = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_CUR      = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_CNT_EN   = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_IRQ_EN   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_STAT     = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_WK_EN    = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_WK_IRQEN = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_WK_STAT  = 8'h4C;
  localparam logic [ADDR_W-1:0] OFF_WAKE_CFG = 8'h50;

  typedef struct packed {
    logic loadWr;
    logic cntEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/countdown_alarm_dp.sv
module countdown_alarm_dp
  import countdown_alarm_pkg::*;
#(
  parameter int CNT_W = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  ctrlStrobes_t     st,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] curVal,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic reloadReq;
  logic armed;

  // Expiry: last decrement from 1 to 0, never on a reload or load-write cycle.
  assign expire = tick & st.cntEn & armed & ~reloadReq & ~st.loadWr & (curVal == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadVal   <= '0;
      curVal    <= '0;
      reloadReq <= 1'b0;
      armed     <= 1'b0;
    end else if (st.loadWr) begin
      loadVal   <= wrData;
      reloadReq <= 1'b1;
    end else if (tick) begin
      if (reloadReq) begin
        curVal    <= loadVal;
        reloadReq <= 1'b0;
        armed     <= (loadVal != '0);
      end else if (st.cntEn && armed) begin
        curVal <= curVal - ONE;
        if (curVal == ONE) armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/countdown_alarm_ctrl.sv
module countdown_alarm_ctrl
  import countdown_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrBit,
  input  logic              weekHit,
  input  logic              expire,
  input  logic [DATA_W-1:0] loadVal,
  input  logic [DATA_W-1:0] curVal,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctrlStrobes_t      st,
  output logic [DATA_W-1:0] rdData,
  output logic              alarmPend,
  output logic              irqEnBit,
  output logic              wakeBit,
  output logic              alarmIrq,
  output logic              wakeOut,
  output logic              weekIrq
);
  logic cntEnBit, weekEnBit, weekIrqEnBit, weekPend;
  logic clrPend, clrWeek;

  assign clrPend = wrEn && (wrAddr == OFF_STAT) && wrBit;
  assign clrWeek = wrEn && (wrAddr == OFF_WK_STAT) && wrBit;

  assign st.loadWr = wrEn && (wrAddr == OFF_LOAD);
  assign st.cntEn  = cntEnBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntEnBit     <= 1'b0;
      irqEnBit     <= 1'b0;
      wakeBit      <= 1'b0;
      weekEnBit    <= 1'b0;
      weekIrqEnBit <= 1'b0;
      alarmPend    <= 1'b0;
      weekPend     <= 1'b0;
    end else begin
      if (wrEn) begin
        unique case (wrAddr)
          OFF_CNT_EN:   cntEnBit     <= wrBit;
          OFF_IRQ_EN:   irqEnBit     <= wrBit;
          OFF_WAKE_CFG: wakeBit      <= wrBit;
          OFF_WK_EN:    weekEnBit    <= wrBit;
          OFF_WK_IRQEN: weekIrqEnBit <= wrBit;
          default: ;
        endcase
      end
      // A new event outranks a clear in the same cycle.
      alarmPend <= expire | (alarmPend & ~clrPend);
      weekPend  <= (weekHit & weekEnBit) | (weekPend & ~clrWeek);
    end
  end

  assign alarmIrq = alarmPend & irqEnBit;
  assign wakeOut  = alarmPend & wakeBit;
  assign weekIrq  = weekPend & weekIrqEnBit;

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      OFF_LOAD:     rdData = loadVal;
      OFF_CUR:      rdData = curVal;
      OFF_CNT_EN:   rdData[0] = cntEnBit;
      OFF_IRQ_EN:   rdData[0] = irqEnBit;
      OFF_STAT:     rdData[0] = alarmPend;
      OFF_WK_EN:    rdData[0] = weekEnBit;
      OFF_WK_IRQEN: rdData[0] = weekIrqEnBit;
      OFF_WK_STAT:  rdData[0] = weekPend;
      OFF_WAKE_CFG: rdData[0] = wakeBit;
      default:      rdData = '0;
    endcase
  end
endmodule

// File: rtl/countdown_alarm.sv
module countdown_alarm
  import countdown_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              weekHit,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              alarmIrq,
  output logic              wakeOut,
  output logic              weekIrq
);
  ctrlStrobes_t      st;
  logic [DATA_W-1:0] loadVal, curVal;
  logic              expire, alarmPend, irqEnBit, wakeBit;

  countdown_alarm_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrBit(wrData[0]),
    .weekHit(weekHit), .expire(expire), .loadVal(loadVal), .curVal(curVal),
    .rdAddr(rdAddr), .st(st), .rdData(rdData), .alarmPend(alarmPend),
    .irqEnBit(irqEnBit), .wakeBit(wakeBit), .alarmIrq(alarmIrq),
    .wakeOut(wakeOut), .weekIrq(weekIrq)
  );

  countdown_alarm_dp #(.CNT_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .tick(tick), .st(st), .wrData(wrData),
    .loadVal(loadVal), .curVal(curVal), .expire(expire)
  );
endmodule

// File: rtl/countdown_alarm_checker.sv
module countdown_alarm_checker
  import countdown_alarm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              wrBit,
  input logic [DATA_W-1:0] curVal,
  input logic              alarmPend,
  input logic              irqEnBit,
  input logic              wakeBit,
  input logic              alarmIrq,
  input logic              wakeOut
);
  assert_count_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(curVal));

  assert_expiry_at_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmPend) |-> (curVal == '0));

  assert_expiry_needs_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> !$rose(alarmPend));

  assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == OFF_STAT && wrBit && !tick) |=> !alarmPend);

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> irqEnBit);

  assert_wake_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> wakeBit);
endmodule

bind countdown_alarm countdown_alarm_checker uChk (
  .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrBit(wrData[0]), .curVal(curVal), .alarmPend(alarmPend),
  .irqEnBit(irqEnBit), .wakeBit(wakeBit), .alarmIrq(alarmIrq), .wakeOut(wakeOut)
);

// File: tb/countdown_alarm_test.sv
module countdown_alarm_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        weekHit = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        alarmIrq, wakeOut, weekIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  typedef struct {
    bit          isPins;
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  countdown_alarm uut (
    .clk(clk), .rstN(rstN), .tick(tick), .weekHit(weekHit), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .alarmIrq(alarmIrq), .wakeOut(wakeOut), .weekIrq(weekIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: compares queued expectations a quarter period after the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (sbq.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sbq.pop_front();
        act = it.isPins ? {29'b0, weekIrq, wakeOut, alarmIrq} : rdData;
        nChecks++;
        if (act !== it.exp) begin
          nFails++;
          $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
        end
      end
    end
  end

  task automatic write(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic writeTick(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d; tick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tick = 1'b0;
  endtask

  task automatic secTick(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic expReg(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    rdAddr = a;
    it.isPins = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  // Pin order: bit0 alarmIrq, bit1 wakeOut, bit2 weekIrq.
  task automatic expPins(input logic [2:0] e, input string tag);
    item_t it;
    it.isPins = 1'b1; it.addr = '0; it.exp = {29'b0, e}; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    expReg(8'h20, 0, "R1 load");
    expReg(8'h24, 0, "R1 cur");
    expReg(8'h30, 0, "R1 stat");
    expReg(8'h4C, 0, "R1 week stat");
    expPins(3'b000, "R1 pins");

    // R2 load and copy on tick
    write(8'h20, 3);
    expReg(8'h20, 3, "R2 load readback");
    expReg(8'h24, 0, "R2 no copy before tick");
    write(8'h28, 1);
    write(8'h2C, 1);
    secTick(1);
    expReg(8'h24, 3, "R2 copy on tick");
    // R3 decrement and hold
    secTick(1);
    expReg(8'h24, 2, "R3 decrement");
    repeat (4) @(negedge clk);
    expReg(8'h24, 2, "R3 hold without tick");
    secTick(1);
    expReg(8'h30, 0, "R4 no early expiry");
    secTick(1);
    expReg(8'h30, 1, "R4 pending at zero");
    expPins(3'b001, "R7 irq with enable, no wake");
    secTick(3);
    expReg(8'h24, 0, "R4 stays at zero");
    // R5 clear semantics
    write(8'h30, 0);
    expReg(8'h30, 1, "R5 write 0 ignored");
    write(8'h30, 1);
    expReg(8'h30, 0, "R5 w1c clears");
    expPins(3'b000, "R7 irq drops");
    secTick(2);
    expReg(8'h30, 0, "R4 no re-expiry");

    // R8 wakeup independent of irq enable
    write(8'h50, 1);
    write(8'h2C, 0);
    write(8'h20, 2);
    secTick(3);
    expPins(3'b010, "R8 wake without irq");
    write(8'h2C, 1);
    expPins(3'b011, "R7 R8 both");
    write(8'h30, 1);
    write(8'h50, 0);

    // R3 counting disabled holds count
    write(8'h20, 5);
    secTick(1);
    write(8'h28, 0);
    secTick(2);
    expReg(8'h24, 5, "R3 hold when disabled");
    write(8'h28, 1);
    secTick(1);
    expReg(8'h24, 4, "R3 resumes");

    // R9 zero then restart
    write(8'h20, 0);
    secTick(1);
    expReg(8'h24, 0, "R9 zero copied");
    secTick(2);
    expReg(8'h30, 0, "R9 zero no expiry");
    write(8'h20, 2);
    secTick(1);
    expReg(8'h24, 2, "R9 restart value");
    secTick(2);
    expReg(8'h30, 1, "R9 restart expires");

    // R6 set beats clear
    write(8'h30, 1);
    write(8'h20, 1);
    secTick(1);
    expReg(8'h30, 0, "R6 pre clear");
    writeTick(8'h30, 1);
    expReg(8'h30, 1, "R6 set wins");
    write(8'h30, 1);
    expReg(8'h30, 0, "R6 later clear");

    // R10 weekly alarm
    weekHit = 1'b1; @(negedge clk); weekHit = 1'b0;
    expReg(8'h4C, 0, "R10 ignored when disabled");
    write(8'h44, 1);
    write(8'h48, 1);
    weekHit = 1'b1; @(negedge clk); weekHit = 1'b0;
    expReg(8'h4C, 1, "R10 week pending");
    expPins(3'b100, "R10 weekIrq");
    write(8'h4C, 1);
    expReg(8'h4C, 0, "R10 week clear");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule